// File: doc/BRIEF.md
# Performance Counter Access Front End

This block sits between the register-access path and two banks of performance counters: a general bank and a fixed bank. It turns write requests into conditioned storage updates and turns a 32-bit read-by-index operand into either counter data or a fault. The general counters can be written through two aliases with different rules. The legacy alias takes a 32-bit value and sign-extends it. The full-width alias takes the value as given, but only when the full-width capability is on and no bit above the counter width is set. A third write alias loads the fixed counters. The counters are held inside the block as plain registers and are never counted here. The conditioned write is also driven out on the `st_*` ports, so the counting logic next to the block can follow it.

Read and write results come out one cycle after the request. Two small state machines produce them. The read-response machine has the states `RSP_IDLE`, `RSP_DATA` and `RSP_FAULT`, and on every clock it moves to one of them. Transition `go_idle` is taken when no read is requested. `go_data` is taken when the index decodes cleanly. `go_fault` is taken when the index names a counter that does not exist or sets a reserved bit. The write-result machine has the states `WST_IDLE`, `WST_DONE` and `WST_REJECT`. It moves on `wr_none` when there is no write, on `wr_accept` when the storage is updated and on `wr_reject` when the write faults.

Top module: `ctr_access_front`

## Requirements
- R1: A write with alias code 0 (legacy) to general counter n keeps wr_data[31:0], sign-extends it from bit 31 and stores the result masked to GP_W bits.
- R2: A write with alias code 1 (full-width) stores wr_data unchanged when cap_full_wr is 1, n < NUM_GP and every bit of wr_data at or above GP_W is 0.
- R3: A full-width write with any bit of wr_data at or above GP_W set faults: wr_fault is 1 in the next cycle, st_we stays 0 and the counter keeps its value.
- R4: A full-width write while cap_full_wr is 0 faults and leaves the counter unchanged.
- R5: Both general aliases update the same register, so a later write through one alias replaces a value written through the other, and a read returns the most recent value.
- R6: Read index bit 30 selects the fixed bank (1) or the general bank (0), and bits [NUM_FIELD_W-1:0] select the counter. A write with alias code 2 stores wr_data masked to FIX_W bits into fixed counter n.
- R7: When read index bit 31 is set, the read returns the selected counter's bits 31:0 zero-extended to 64 bits.
- R8: A counter number that is out of range for its bank (for example 64, or 4 general / 3 fixed with the default parameters) faults on a read and on a write, and stores nothing.
- R9: A normal read returns the whole counter value, which has no bit set at or above that bank's width.
- R10: A read index with any bit in [29:NUM_FIELD_W] set faults.
- R11: rd_valid, rd_fault, rd_data and wr_fault show the outcome of the request made in the previous cycle. rd_valid and rd_fault are never 1 together. Both are 0, and rd_data is 0, after a cycle with no read. A read made in the same cycle as a write returns the value from before that write.
- R12: After reset all counters read 0 and every output is 0.
- R13: A write with alias code 3 is reserved and always faults without storing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_full_wr | input | 1 | Full-width write capability enable |
| wr_req | input | 1 | Write request |
| wr_alias | input | 2 | Write alias: 0 legacy, 1 full-width, 2 fixed, 3 reserved |
| wr_num | input | NUM_FIELD_W | Counter number within the bank the alias targets |
| wr_data | input | 64 | Write data |
| rd_req | input | 1 | Read-by-index request |
| rd_index | input | 32 | Read operand: bit 31 fast, bit 30 fixed bank, low field counter number |
| st_we | output | 1 | Conditioned storage write enable |
| st_bank | output | 1 | Bank of the storage write (1 = fixed) |
| st_num | output | NUM_FIELD_W | Counter number of the storage write |
| st_val | output | 64 | Conditioned value written to storage |
| wr_fault | output | 1 | Previous-cycle write faulted |
| rd_valid | output | 1 | rd_data carries the previous-cycle read |
| rd_data | output | 64 | Read result |
| rd_fault | output | 1 | Previous-cycle read faulted |

## Verification
The assertions assume that GP_W is above 32 and at most 64, that FIX_W is at most 64, and that NUM_FIELD_W is below 30. These conditions keep the sign-extension and reserved-bit fields meaningful. The default parameters meet them, and the bench keeps to them. The assertions also assume that inputs only change away from the rising edge. The bench meets this by driving every request on the falling edge and holding it for one full cycle. Its random phase only draws counter numbers, alias codes and index flags from the encodings listed in the requirements. It covers in-range numbers, out-of-range numbers and reserved-bit cases, so every fault path is taken without going outside the encodings the properties describe.

// File: rtl/ctr_acc_pkg.sv
`timescale 1ns/1ps
package ctr_acc_pkg;

    typedef enum logic [1:0] {
        ALIAS_LEGACY = 2'd0,
        ALIAS_FULL   = 2'd1,
        ALIAS_FIXED  = 2'd2,
        ALIAS_RSVD   = 2'd3
    } wr_alias_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DATA  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

    typedef enum logic [1:0] {
        WST_IDLE   = 2'd0,
        WST_DONE   = 2'd1,
        WST_REJECT = 2'd2
    } wst_state_e;

    localparam int IDX_FAST_BIT = 31;
    localparam int IDX_BANK_BIT = 30;

endpackage

// File: rtl/acc_wr_cond.sv
`timescale 1ns/1ps
module acc_wr_cond
    import ctr_acc_pkg::*;
#(
    parameter int NUM_GP      = 4,
    parameter int NUM_FIX     = 3,
    parameter int GP_W        = 48,
    parameter int FIX_W       = 40,
    parameter int NUM_FIELD_W = 8
) (
    input  logic                   wr_req,
    input  logic [1:0]             wr_alias,
    input  logic [NUM_FIELD_W-1:0] wr_num,
    input  logic [63:0]            wr_data,
    input  logic                   cap_full_wr,
    output logic                   st_we,
    output logic                   st_bank,
    output logic [63:0]            st_val,
    output logic                   reject
);
    localparam logic [63:0] GP_MASK  = (GP_W >= 64)  ? {64{1'b1}} : ((64'd1 << GP_W) - 64'd1);
    localparam logic [63:0] FIX_MASK = (FIX_W >= 64) ? {64{1'b1}} : ((64'd1 << FIX_W) - 64'd1);
    localparam logic [NUM_FIELD_W-1:0] GP_CNT  = NUM_FIELD_W'(NUM_GP);
    localparam logic [NUM_FIELD_W-1:0] FIX_CNT = NUM_FIELD_W'(NUM_FIX);

    logic        ok;
    logic        above_width;
    logic [63:0] sext_val;

    always_comb begin
        sext_val    = {{32{wr_data[31]}}, wr_data[31:0]} & GP_MASK;
        above_width = |(wr_data & ~GP_MASK);
        ok          = 1'b0;
        st_bank     = 1'b0;
        st_val      = '0;
        unique case (wr_alias_e'(wr_alias))
            ALIAS_LEGACY: begin
                ok     = (wr_num < GP_CNT);
                st_val = sext_val;
            end
            ALIAS_FULL: begin
                ok     = (wr_num < GP_CNT) && cap_full_wr && !above_width;
                st_val = wr_data & GP_MASK;
            end
            ALIAS_FIXED: begin
                ok      = (wr_num < FIX_CNT);
                st_bank = 1'b1;
                st_val  = wr_data & FIX_MASK;
            end
            ALIAS_RSVD: begin
                ok = 1'b0;
            end
        endcase
        st_we  = wr_req && ok;
        reject = wr_req && !ok;
    end
endmodule

// File: rtl/acc_rd_decode.sv
`timescale 1ns/1ps
module acc_rd_decode
    import ctr_acc_pkg::*;
#(
    parameter int NUM_GP      = 4,
    parameter int NUM_FIX     = 3,
    parameter int NUM_FIELD_W = 8
) (
    input  logic [31:0]            rd_index,
    output logic                   dec_fast,
    output logic                   dec_fixed,
    output logic [NUM_FIELD_W-1:0] dec_num,
    output logic                   dec_bad
);
    localparam logic [NUM_FIELD_W-1:0] GP_CNT  = NUM_FIELD_W'(NUM_GP);
    localparam logic [NUM_FIELD_W-1:0] FIX_CNT = NUM_FIELD_W'(NUM_FIX);

    logic rsvd_set;
    logic in_range;

    always_comb begin
        dec_fast  = rd_index[IDX_FAST_BIT];
        dec_fixed = rd_index[IDX_BANK_BIT];
        dec_num   = rd_index[NUM_FIELD_W-1:0];
        rsvd_set  = |rd_index[29:NUM_FIELD_W];
        in_range  = dec_fixed ? (dec_num < FIX_CNT) : (dec_num < GP_CNT);
        dec_bad   = rsvd_set || !in_range;
    end
endmodule

// File: rtl/acc_cnt_bank.sv
`timescale 1ns/1ps
module acc_cnt_bank #(
    parameter int N           = 4,
    parameter int W           = 48,
    parameter int NUM_FIELD_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [NUM_FIELD_W-1:0] wnum,
    input  logic [W-1:0]           wval,
    input  logic [NUM_FIELD_W-1:0] rnum,
    output logic [63:0]            rval
);
    logic [W-1:0] cnt_q [N];

    for (genvar g = 0; g < N; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (we && wnum == NUM_FIELD_W'(g)) begin
                cnt_q[g] <= wval;
            end
        end
    end

    always_comb begin
        rval = '0;
        for (int i = 0; i < N; i++) begin
            if (rnum == NUM_FIELD_W'(i)) begin
                rval[W-1:0] = cnt_q[i];
            end
        end
    end
endmodule

// File: rtl/ctr_access_front.sv
`timescale 1ns/1ps
module ctr_access_front
    import ctr_acc_pkg::*;
#(
    parameter int NUM_GP      = 4,
    parameter int NUM_FIX     = 3,
    parameter int GP_W        = 48,
    parameter int FIX_W       = 40,
    parameter int NUM_FIELD_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_full_wr,
    input  logic                   wr_req,
    input  logic [1:0]             wr_alias,
    input  logic [NUM_FIELD_W-1:0] wr_num,
    input  logic [63:0]            wr_data,
    input  logic                   rd_req,
    input  logic [31:0]            rd_index,
    output logic                   st_we,
    output logic                   st_bank,
    output logic [NUM_FIELD_W-1:0] st_num,
    output logic [63:0]            st_val,
    output logic                   wr_fault,
    output logic                   rd_valid,
    output logic [63:0]            rd_data,
    output logic                   rd_fault
);
    localparam logic [63:0] GP_MASK = (GP_W >= 64) ? {64{1'b1}} : ((64'd1 << GP_W) - 64'd1);
    localparam logic [NUM_FIELD_W-1:0] GP_CNT = NUM_FIELD_W'(NUM_GP);

    logic                   reject;
    logic                   dec_fast;
    logic                   dec_fixed;
    logic                   dec_bad;
    logic [NUM_FIELD_W-1:0] dec_num;
    logic [63:0]            gp_rval;
    logic [63:0]            fix_rval;
    logic [63:0]            sel_val;
    logic [63:0]            fetch_val;
    logic [63:0]            rd_q;
    rsp_state_e             rsp_q, rsp_d;
    wst_state_e             wst_q, wst_d;

    acc_wr_cond #(
        .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .GP_W(GP_W),
        .FIX_W(FIX_W), .NUM_FIELD_W(NUM_FIELD_W)
    ) u_wr (
        .wr_req(wr_req), .wr_alias(wr_alias), .wr_num(wr_num),
        .wr_data(wr_data), .cap_full_wr(cap_full_wr),
        .st_we(st_we), .st_bank(st_bank), .st_val(st_val), .reject(reject)
    );

    assign st_num = wr_num;

    acc_rd_decode #(
        .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .NUM_FIELD_W(NUM_FIELD_W)
    ) u_dec (
        .rd_index(rd_index), .dec_fast(dec_fast), .dec_fixed(dec_fixed),
        .dec_num(dec_num), .dec_bad(dec_bad)
    );

    acc_cnt_bank #(.N(NUM_GP), .W(GP_W), .NUM_FIELD_W(NUM_FIELD_W)) u_gp (
        .clk(clk), .rst_n(rst_n), .we(st_we && !st_bank), .wnum(wr_num),
        .wval(st_val[GP_W-1:0]), .rnum(dec_num), .rval(gp_rval)
    );

    acc_cnt_bank #(.N(NUM_FIX), .W(FIX_W), .NUM_FIELD_W(NUM_FIELD_W)) u_fix (
        .clk(clk), .rst_n(rst_n), .we(st_we && st_bank), .wnum(wr_num),
        .wval(st_val[FIX_W-1:0]), .rnum(dec_num), .rval(fix_rval)
    );

    // Next-state selection for both response machines
    always_comb begin
        sel_val   = dec_fixed ? fix_rval : gp_rval;
        fetch_val = dec_fast ? {32'h0, sel_val[31:0]} : sel_val;
        if (!rd_req)       rsp_d = RSP_IDLE;   // go_idle
        else if (dec_bad)  rsp_d = RSP_FAULT;  // go_fault
        else               rsp_d = RSP_DATA;   // go_data
        if (reject)        wst_d = WST_REJECT; // wr_reject
        else if (st_we)    wst_d = WST_DONE;   // wr_accept
        else               wst_d = WST_IDLE;   // wr_none
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= RSP_IDLE;
            wst_q <= WST_IDLE;
            rd_q  <= '0;
        end else begin
            rsp_q <= rsp_d;
            wst_q <= wst_d;
            rd_q  <= (rsp_d == RSP_DATA) ? fetch_val : '0;
        end
    end

    // Outputs from state
    always_comb begin
        rd_valid = 1'b0;
        rd_fault = 1'b0;
        rd_data  = '0;
        unique case (rsp_q)
            RSP_DATA: begin
                rd_valid = 1'b1;
                rd_data  = rd_q;
            end
            RSP_FAULT: rd_fault = 1'b1;
            default: ;
        endcase
        wr_fault = (wst_q == WST_REJECT);
    end

    assert_legacy_sext_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && wr_alias == ALIAS_LEGACY) |->
        (st_val[31:0] == wr_data[31:0] && st_val[GP_W-1:32] == {(GP_W-32){wr_data[31]}}));

    assert_full_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_alias == ALIAS_FULL && cap_full_wr && wr_num < GP_CNT
         && (wr_data & ~GP_MASK) == 64'd0) |-> (st_we && st_val == wr_data));

    assert_overwidth_nostore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_alias == ALIAS_FULL && (wr_data & ~GP_MASK) != 64'd0) |-> !st_we);

    assert_overwidth_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_alias == ALIAS_FULL && (wr_data & ~GP_MASK) != 64'd0) |=> wr_fault);

    assert_no_cap_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_alias == ALIAS_FULL && !cap_full_wr) |=> wr_fault);

    assert_fast_hi_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_index[IDX_FAST_BIT])) |-> rd_data[63:32] == 32'h0);

    assert_range_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_index[IDX_BANK_BIT] && rd_index[NUM_FIELD_W-1:0] >= GP_CNT) |=> rd_fault);

    assert_gp_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(rd_index[IDX_FAST_BIT]) && !$past(rd_index[IDX_BANK_BIT]))
        |-> (rd_data & ~GP_MASK) == 64'd0);

    assert_rsvd_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && |rd_index[29:NUM_FIELD_W]) |=> rd_fault);

    assert_idle_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && !rd_fault && rd_data == 64'd0));

    assert_resp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, rd_fault}));

    assert_rsvd_alias_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_alias == ALIAS_RSVD) |=> wr_fault);
endmodule

// File: tb/tb_ctr_access_front.sv
`timescale 1ns/1ps
module tb_ctr_access_front;
    localparam logic [63:0] GPM  = 64'h0000_FFFF_FFFF_FFFF;
    localparam logic [63:0] FIXM = 64'h0000_00FF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_full_wr = 1'b0;
    logic        wr_req = 1'b0;
    logic [1:0]  wr_alias = 2'd0;
    logic [7:0]  wr_num = 8'd0;
    logic [63:0] wr_data = 64'd0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_index = 32'd0;
    logic        st_we, st_bank, wr_fault, rd_valid, rd_fault;
    logic [7:0]  st_num;
    logic [63:0] st_val, rd_data;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [63:0] gpm [4];
    logic [63:0] fxm [3];

    always #10 clk = ~clk;

    ctr_access_front dut (
        .clk(clk), .rst_n(rst_n), .cap_full_wr(cap_full_wr),
        .wr_req(wr_req), .wr_alias(wr_alias), .wr_num(wr_num), .wr_data(wr_data),
        .rd_req(rd_req), .rd_index(rd_index),
        .st_we(st_we), .st_bank(st_bank), .st_num(st_num), .st_val(st_val),
        .wr_fault(wr_fault), .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault)
    );

    // One request cycle: drive at a falling edge, compare at the next one.
    task automatic step(input bit wq, input logic [1:0] wa, input logic [7:0] wn,
                        input logic [63:0] wd, input bit rq, input logic [31:0] ri,
                        input string tag);
        bit          e_v, e_f, e_wf;
        logic [63:0] e_d, v;
        int          n;
        bit          inr;
        wr_req = wq; wr_alias = wa; wr_num = wn; wr_data = wd;
        rd_req = rq; rd_index = ri;
        e_v = 0; e_f = 0; e_d = 0; e_wf = 0;
        if (rq) begin
            n   = int'(ri[7:0]);
            inr = ri[30] ? (n < 3) : (n < 4);
            if (ri[29:8] != 0 || !inr) e_f = 1;
            else begin
                v = ri[30] ? fxm[n] : gpm[n];
                if (ri[31]) v = v & 64'h0000_0000_FFFF_FFFF;
                e_v = 1; e_d = v;
            end
        end
        @(posedge clk);
        if (wq) begin
            n = int'(wn);
            case (wa)
                2'd0: if (n < 4) gpm[n] = {{32{wd[31]}}, wd[31:0]} & GPM; else e_wf = 1;
                2'd1: if (n < 4 && cap_full_wr && (wd & ~GPM) == 0) gpm[n] = wd; else e_wf = 1;
                2'd2: if (n < 3) fxm[n] = wd & FIXM; else e_wf = 1;
                default: e_wf = 1;
            endcase
        end
        @(negedge clk);
        checks++;
        if (rd_valid !== e_v || rd_fault !== e_f || rd_data !== e_d || wr_fault !== e_wf) begin
            fails++;
            $display("FAIL %s: got v=%0b f=%0b d=%h wf=%0b expected v=%0b f=%0b d=%h wf=%0b",
                     tag, rd_valid, rd_fault, rd_data, wr_fault, e_v, e_f, e_d, e_wf);
        end
    endtask

    task automatic rd(input logic [31:0] ri, input string tag);
        step(0, 2'd0, 8'd0, 64'd0, 1, ri, tag);
    endtask

    task automatic wr(input logic [1:0] wa, input logic [7:0] wn, input logic [63:0] wd,
                      input string tag);
        step(1, wa, wn, wd, 0, 32'd0, tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) gpm[i] = 0;
        for (int i = 0; i < 3; i++) fxm[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: outputs after reset
        checks++;
        if (rd_valid !== 0 || rd_fault !== 0 || rd_data !== 0 || wr_fault !== 0 || st_we !== 0) begin
            fails++;
            $display("FAIL R12 reset outputs: got v=%0b f=%0b d=%h wf=%0b expected all 0",
                     rd_valid, rd_fault, rd_data, wr_fault);
        end
        for (int i = 0; i < 4; i++) rd(32'(i), "R12 general reads zero");
        for (int i = 0; i < 3; i++) rd(32'h4000_0000 | 32'(i), "R12 fixed reads zero");

        wr(2'd0, 8'd0, 64'h0000_FF01_2345_6789, "R1 legacy positive");
        rd(32'd0, "R1 legacy positive readback");
        wr(2'd0, 8'd1, 64'h0000_0000_89AB_CDEF, "R1 legacy sign extend");
        rd(32'd1, "R1 legacy sign extend readback");

        cap_full_wr = 1'b1;
        wr(2'd1, 8'd2, 64'h0000_FF01_2345_6789, "R2 full-width store");
        rd(32'd2, "R9 normal read full value");
        rd(32'h8000_0002, "R7 fast read low half");
        rd(32'h8000_0001, "R7 fast read of sign-extended");
        wr(2'd1, 8'd3, 64'hFFFF_FF01_2345_6789, "R3 over-width write faults");
        rd(32'd3, "R3 counter unchanged");
        wr(2'd1, 8'd3, 64'h0001_0000_0000_0000, "R3 single bit at width faults");

        cap_full_wr = 1'b0;
        wr(2'd1, 8'd0, 64'h1234, "R4 no capability faults");
        rd(32'd0, "R4 counter unchanged");
        cap_full_wr = 1'b1;

        wr(2'd1, 8'd1, 64'h0000_7777_0000_1111, "R5 full-width write");
        rd(32'd1, "R5 full-width visible");
        wr(2'd0, 8'd1, 64'h0000_0000_DEAD_BEEF, "R5 legacy overwrite");
        rd(32'd1, "R5 legacy visible through same storage");

        wr(2'd2, 8'd1, 64'h0000_FF01_2345_6789, "R6 fixed write masked");
        rd(32'h4000_0001, "R6 fixed bank read");
        rd(32'hC000_0001, "R7 fixed fast read");
        wr(2'd2, 8'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 fixed write all ones");
        rd(32'h4000_0000, "R6 fixed 0 read");
        rd(32'h0000_0000, "R6 general 0 differs from fixed 0");

        rd(32'd64, "R8 read index 64 faults");
        rd(32'd4, "R8 general number 4 faults");
        rd(32'h4000_0003, "R8 fixed number 3 faults");
        wr(2'd0, 8'd4, 64'h55, "R8 write number 4 faults");
        wr(2'd2, 8'd3, 64'h55, "R8 fixed write number 3 faults");
        rd(32'd3, "R8 nothing stored");

        rd(32'h0000_1000, "R10 reserved bit 12 faults");
        rd(32'h2000_0001, "R10 reserved bit 29 faults");
        wr(2'd3, 8'd0, 64'h1, "R13 reserved alias faults");
        rd(32'd0, "R13 nothing stored");

        step(0, 2'd0, 8'd0, 64'd0, 0, 32'd0, "R11 idle cycle");
        step(1, 2'd0, 8'd2, 64'h0000_0000_0000_00AA, 1, 32'd2, "R11 read sees pre-write value");
        rd(32'd2, "R11 write visible next");

        for (int k = 0; k < 400; k++) begin
            logic [31:0] ri;
            logic [7:0]  wn;
            logic [63:0] wd;
            int sel;
            sel = int'($urandom_range(0, 9));
            ri  = {$urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 22'd0, 8'($urandom_range(0, 5))};
            if (sel == 0) ri[8 + $urandom_range(0, 21)] = 1'b1;
            if (sel == 1) ri[7:0] = 8'd64;
            wn = 8'($urandom_range(0, 4));
            wd = {$urandom, $urandom};
            if (sel > 5) wd[63:48] = 16'h0;
            cap_full_wr = ($urandom_range(0, 7) != 0);
            step($urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), wn, wd,
                 $urandom_range(0, 2) != 0, ri, "R11 random mix");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule